// File: doc/BRIEF.md
# MDIO Management Access Controller

This block lets software read and write the management registers of Ethernet PHYs over the two-wire MDC/MDIO pair. Software works through three 32-bit registers on a simple synchronous register port. A control register turns the controller on, sets the MDC clock divider and shows whether the frame engine is idle. An alive register holds one bit per PHY address. A user-access register takes a complete command and later returns the result.

To issue a command, software writes the user-access register with GO set. It then reads the register until GO has cleared. At that point the acknowledge bit and, for a read, the returned data are valid. While no command is pending and the controller is enabled, it keeps reading register 1 of every PHY address in turn. Each answer updates the alive bit for that address, so a PHY that disappears loses its bit on the next pass.

The register map is: index 0 is control, index 1 is the alive bitmap, index 2 is user access, and index 3 reads zero. Frames are 64 bits in the standard management format.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the control register reads 0x8000_0000 (idle flag set, enable clear, divider 0). The alive and user-access registers read 0. MDC is low and the MDIO driver is off.
- R2: While control bit 30 (enable) is 0, no frame starts. MDC stays low, the MDIO driver stays off and control bit 31 (idle) reads 1.
- R3: During a frame, MDC has a period of 2*(D+1) system clocks, where D is control bits 7:0.
- R4: A frame consists of, in this order:
  - 32 ones;
  - the start bits 0 then 1;
  - the opcode, 10 for a read and 01 for a write;
  - the PHY address, MSB first;
  - the register address, MSB first;
  - two turnaround bits, driven 1 then 0 on a write;
  - 16 data bits, MSB first.

  MDIO changes after a falling MDC edge and is sampled on a rising edge.
- R5: The user-access register has these fields:
  - bit 31 is GO;
  - bit 30 is write (1) or read (0);
  - bit 29 is ACK, read-only;
  - bits 25:21 are the register address;
  - bits 20:16 are the PHY address;
  - bits 15:0 are data.

  Writing GO=1 starts a command. GO reads 1 until that frame ends and then clears by itself.
- R6: On a read, ACK is set when the PHY holds MDIO low in the second turnaround bit, and bits 15:0 return the 16 bits shifted in. With no PHY answering, ACK reads 0.
- R7: A completed write always reports ACK=1.
- R8: A write to the user-access register while GO reads 1 has no effect: the stored command and the frame sent are those of the first write.
- R9: On a read frame, the controller releases MDIO from the first turnaround bit through the last data bit.
- R10: With no command pending, the controller reads register 1 of PHY addresses 0 to 31 in rotation. After each poll it sets or clears that address's alive bit according to ACK.
- R11: Control bit 31 reads 0 while a frame is in progress.
- R12: A pending user command is sent as the next frame, right after any poll frame already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register index: 0 control, 1 alive, 2 user access |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr, combinational |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO line level as seen at the pad |

## Verification
The assertions assume three things about the inputs. First, mdioIn is a clean level that is already synchronous to the system clock. Second, software changes the divider only between frames, or accepts a stretched MDC half-period. Third, frame completion is the only event that may clear GO or alter the alive bitmap. The bench respects these assumptions. Its PHY model changes its MDIO drive only on falling MDC edges. It waits for GO to clear before the next command, except in the one deliberate overlapping write that checks the ignore rule. It changes the divider only at points where the frame in flight keeps a valid timing relationship.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W  = 5;
  localparam int NUM_PHY = 1 << ADDR_W;
  localparam int FRAME_W = 64;

  // frame bit positions the shift engine decodes
  localparam logic [5:0] BIT_TA_FIRST  = 6'd46;
  localparam logic [5:0] BIT_TA_SECOND = 6'd47;
  localparam logic [5:0] BIT_DATA_FIRST = 6'd48;
  localparam logic [5:0] BIT_LAST      = 6'd63;

  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_ALIVE = 2'd1;
  localparam logic [1:0] REG_USER  = 2'd2;

  localparam logic [ADDR_W-1:0] POLL_REG = 5'd1;

  typedef struct packed {
    logic              start;
    logic              isRead;
    logic [ADDR_W-1:0] phyAddr;
    logic [ADDR_W-1:0] regAddr;
    logic [15:0]       wrData;
  } mdioCmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_USER, ST_POLL} seqState_t;
endpackage

// File: rtl/mdio_shift_engine.sv
module mdio_shift_engine
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdioCmd_t         cmd,
  input  logic [DIV_W-1:0] divider,
  input  logic             mdioIn,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  output logic             frameDone,
  output logic             ackSeen,
  output logic [15:0]      rdData
);
  logic               active;
  logic               isReadQ;
  logic [DIV_W-1:0]   divCnt;
  logic               mdcQ;
  logic [5:0]         bitCnt;
  logic [FRAME_W-1:0] txShift;
  logic [15:0]        rxShift;
  logic               ackQ;
  logic [FRAME_W-1:0] frameWord;

  always_comb begin
    frameWord = {32'hFFFF_FFFF, 2'b01,
                 cmd.isRead ? 2'b10 : 2'b01,
                 cmd.phyAddr, cmd.regAddr,
                 cmd.isRead ? 2'b11 : 2'b10,
                 cmd.isRead ? 16'hFFFF : cmd.wrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      isReadQ   <= 1'b0;
      divCnt    <= '0;
      mdcQ      <= 1'b0;
      bitCnt    <= '0;
      txShift   <= '0;
      rxShift   <= '0;
      ackQ      <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (!active) begin
        divCnt <= '0;
        mdcQ   <= 1'b0;
        if (cmd.start) begin
          active  <= 1'b1;
          isReadQ <= cmd.isRead;
          bitCnt  <= '0;
          txShift <= frameWord;
          ackQ    <= 1'b0;
        end
      end else if (divCnt >= divider) begin
        divCnt <= '0;
        if (!mdcQ) begin
          // rising MDC edge: sample the line
          mdcQ <= 1'b1;
          if (isReadQ) begin
            if (bitCnt == BIT_TA_SECOND) ackQ <= !mdioIn;
            if (bitCnt >= BIT_DATA_FIRST) rxShift <= {rxShift[14:0], mdioIn};
          end
        end else begin
          // falling MDC edge: advance to the next bit
          mdcQ <= 1'b0;
          if (bitCnt == BIT_LAST) begin
            active    <= 1'b0;
            frameDone <= 1'b1;
          end else begin
            bitCnt  <= bitCnt + 6'd1;
            txShift <= {txShift[FRAME_W-2:0], 1'b0};
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign mdc     = mdcQ;
  assign mdioOut = txShift[FRAME_W-1];
  assign mdioOe  = active && !(isReadQ && (bitCnt >= BIT_TA_FIRST));
  assign ackSeen = ackQ;
  assign rdData  = rxShift;
endmodule

// File: rtl/mdio_sequencer.sv
module mdio_sequencer
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         regAddr,
  input  logic               regWrEn,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic               frameDone,
  input  logic               ackSeen,
  input  logic [15:0]        rdData,
  output mdioCmd_t           cmd,
  output logic [DIV_W-1:0]   divider,
  output logic               idleFlag,
  output logic               goBit,
  output logic [NUM_PHY-1:0] aliveMap
);
  localparam int CTRL_PAD = 30 - DIV_W;

  seqState_t         state;
  logic              enable;
  logic [DIV_W-1:0]  divReg;
  logic              goQ;
  logic              wrQ;
  logic              ackQ;
  logic [ADDR_W-1:0] regQ;
  logic [ADDR_W-1:0] phyQ;
  logic [15:0]       dataQ;
  logic [ADDR_W-1:0] pollAddr;
  logic              pollDone;

  assign idleFlag = (state == ST_IDLE);
  assign pollDone = (state == ST_POLL) && frameDone;

  always_comb begin
    cmd.start   = idleFlag && enable;
    cmd.isRead  = goQ ? !wrQ : 1'b1;
    cmd.phyAddr = goQ ? phyQ : pollAddr;
    cmd.regAddr = goQ ? regQ : POLL_REG;
    cmd.wrData  = dataQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      enable   <= 1'b0;
      divReg   <= '0;
      goQ      <= 1'b0;
      wrQ      <= 1'b0;
      ackQ     <= 1'b0;
      regQ     <= '0;
      phyQ     <= '0;
      dataQ    <= '0;
      pollAddr <= '0;
    end else begin
      if (regWrEn && regAddr == REG_CTRL) begin
        enable <= regWrData[30];
        divReg <= regWrData[DIV_W-1:0];
      end
      // a command register write is dropped while GO is set
      if (regWrEn && regAddr == REG_USER && !goQ) begin
        goQ   <= regWrData[31];
        wrQ   <= regWrData[30];
        ackQ  <= 1'b0;
        regQ  <= regWrData[25:21];
        phyQ  <= regWrData[20:16];
        dataQ <= regWrData[15:0];
      end
      unique case (state)
        ST_IDLE: if (enable) state <= goQ ? ST_USER : ST_POLL;
        ST_USER: if (frameDone) begin
          goQ   <= 1'b0;
          ackQ  <= wrQ | ackSeen;
          if (!wrQ) dataQ <= rdData;
          state <= ST_IDLE;
        end
        ST_POLL: if (frameDone) begin
          pollAddr <= pollAddr + 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_PHY; i++) begin : g_alive
    always_ff @(posedge clk) begin
      if (!rstN) aliveMap[i] <= 1'b0;
      else if (pollDone && pollAddr == ADDR_W'(i)) aliveMap[i] <= ackSeen;
    end
  end

  always_comb begin
    unique case (regAddr)
      REG_CTRL:  regRdData = {idleFlag, enable, {CTRL_PAD{1'b0}}, divReg};
      REG_ALIVE: regRdData = aliveMap;
      REG_USER:  regRdData = {goQ, wrQ, ackQ, 3'b000, regQ, phyQ, dataQ};
      default:   regRdData = '0;
    endcase
  end

  assign divider = divReg;
  assign goBit   = goQ;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioCmd_t           cmd;
  logic [DIV_W-1:0]   divider;
  logic               frameDone;
  logic               ackSeen;
  logic [15:0]        rdData;
  logic               idleFlag;
  logic               goBit;
  logic [NUM_PHY-1:0] aliveMap;

  mdio_sequencer #(.DIV_W(DIV_W)) u_seq (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .frameDone(frameDone),
    .ackSeen(ackSeen), .rdData(rdData), .cmd(cmd), .divider(divider),
    .idleFlag(idleFlag), .goBit(goBit), .aliveMap(aliveMap)
  );

  mdio_shift_engine #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rstN(rstN), .cmd(cmd), .divider(divider), .mdioIn(mdioIn),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .frameDone(frameDone),
    .ackSeen(ackSeen), .rdData(rdData)
  );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        mdc,
  input logic        mdioOe,
  input logic        idleFlag,
  input logic        goBit,
  input logic        frameDone,
  input logic [31:0] aliveMap
);
  // R2: no MDC activity while the sequencer is idle
  a_r2_idle_mdc_low: assert property (@(posedge clk) disable iff (!rstN)
    idleFlag |-> !mdc);
  // R2: bus released while idle
  a_r2_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    idleFlag |-> !mdioOe);
  // R5: GO only clears as a frame ends
  a_r5_go_clears_on_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(goBit) |-> $past(frameDone));
  // R10: alive bitmap only changes as a frame ends
  a_r10_alive_on_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(aliveMap) |-> $past(frameDone));
  // R11: an MDC rise never happens while idle is reported
  a_r11_rise_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> !idleFlag);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOe(mdioOe), .idleFlag(idleFlag),
  .goBit(goBit), .frameDone(frameDone), .aliveMap(aliveMap)
);

// File: tb/sim_mdio_mgmt_ctrl.sv
module sim_mdio_mgmt_ctrl;
  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  regAddr;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  always #2.5 clk = ~clk;

  // PHY model state
  logic [31:0] presentMask;
  logic        phyDrive, phyBit;
  int          ones, st, k;
  logic [11:0] hdr;
  logic [15:0] wsh;
  logic [4:0]  lastWrPhy, lastWrReg;
  logic [15:0] lastWrData;
  int          wrCount, taViol, taBad;

  assign mdioIn = mdioOe ? mdioOut : (phyDrive ? phyBit : 1'b1);

  mdio_mgmt_ctrl u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  function automatic logic [15:0] phyVal(input logic [4:0] p, input logic [4:0] r);
    return {~p, r, 6'h2D};
  endfunction

  initial begin
    st = 0; ones = 0; k = 0; hdr = '0; wsh = '0;
    wrCount = 0; taViol = 0; taBad = 0;
    phyDrive = 1'b0; phyBit = 1'b1; presentMask = '0;
    lastWrPhy = '0; lastWrReg = '0; lastWrData = '0;
  end

  always @(posedge mdc) begin
    case (st)
      0: begin
        if (mdioIn) begin if (ones < 40) ones++; end
        else if (ones >= 32) st = 1;
        else ones = 0;
      end
      1: begin
        if (mdioIn) begin st = 2; k = 0; end
        else begin st = 0; ones = 0; end
      end
      default: begin
        if (k < 12) hdr = {hdr[10:0], mdioIn};
        else if (hdr[11:10] == 2'b10) begin
          if (k < 14 && mdioOe) taViol++;
        end else begin
          if (k == 12 && mdioIn != 1'b1) taBad++;
          if (k == 13 && mdioIn != 1'b0) taBad++;
          if (k >= 14) wsh = {wsh[14:0], mdioIn};
        end
        k++;
        if (k == 30) begin
          st = 0; ones = 0;
          if (hdr[11:10] == 2'b01) begin
            lastWrPhy = hdr[9:5]; lastWrReg = hdr[4:0]; lastWrData = wsh;
            wrCount++;
          end
        end
      end
    endcase
  end

  always @(negedge mdc) begin
    logic [15:0] v;
    phyDrive = 1'b0;
    if (st == 2 && k >= 12 && hdr[11:10] == 2'b10 && presentMask[hdr[9:5]]) begin
      v = phyVal(hdr[9:5], hdr[4:0]);
      if (k == 13) begin phyDrive = 1'b1; phyBit = 1'b0; end
      else if (k >= 14 && k <= 29) begin phyDrive = 1'b1; phyBit = v[29-k]; end
    end
  end

  // MDC period and edge counting, sampled away from the active edge
  int  cyc = 0, lastRise = 0, period = 0, riseCount = 0;
  logic mdcPrev = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (mdc && !mdcPrev) begin period = cyc - lastRise; lastRise = cyc; riseCount++; end
    mdcPrev = mdc;
  end

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitGo(output logic [31:0] res, output int cycles);
    cycles = 0;
    do begin regRead(2'd2, res); cycles++; end while (res[31] && cycles < 5000);
  endtask

  task automatic userOp(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] d, output logic [31:0] res, output int cycles);
    regWrite(2'd2, {1'b1, wr, 1'b0, 3'b000, rg, phy, d});
    waitGo(res, cycles);
  endtask

  initial begin
    logic [31:0] r;
    int cy, rc;
    logic [4:0] regList [4];
    logic [4:0] wPhy [3];
    logic [4:0] wReg [2];
    logic [15:0] wDat [3];
    regList = '{5'd0, 5'd1, 5'd17, 5'd31};
    wPhy = '{5'd0, 5'd3, 5'd31};
    wReg = '{5'd2, 5'd30};
    wDat = '{16'hA5C3, 16'h0001, 16'hFFFE};
    rstN = 1'b0; regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(2'd0, r); check(r == 32'h8000_0000, "R1 ctrl", r, 32'h8000_0000);
    regRead(2'd1, r); check(r == 0, "R1 alive", r, 0);
    regRead(2'd2, r); check(r == 0, "R1 user", r, 0);
    check(!mdc && !mdioOe, "R1 pins", {mdc, mdioOe}, 0);

    // R2 disabled: nothing happens
    repeat (300) @(negedge clk);
    check(riseCount == 0, "R2 no mdc", riseCount, 0);
    regRead(2'd0, r); check(r[31] == 1'b1, "R2 idle", r[31], 1);

    // R10 background poll fills the alive map
    presentMask = 32'h8000_0025;
    regWrite(2'd0, 32'h4000_0000);
    repeat (3) @(negedge clk);
    regRead(2'd0, r); check(r[31] == 1'b0, "R11 busy", r[31], 0);
    repeat (9000) @(negedge clk);
    regRead(2'd1, r); check(r == presentMask, "R10 alive", r, presentMask);
    check(period == 2, "R3 div0 period", period, 2);

    // R6 read sweep over all addresses
    for (int p = 0; p < 32; p++) begin
      for (int ri = 0; ri < 4; ri++) begin
        userOp(1'b0, 5'(p), regList[ri], 16'h0000, r, cy);
        check(r[29] == presentMask[p], "R6 ack", r[29], presentMask[p]);
        if (presentMask[p])
          check(r[15:0] == phyVal(5'(p), regList[ri]), "R6 data", r[15:0],
                phyVal(5'(p), regList[ri]));
        check(r[25:16] == {regList[ri], 5'(p)} && r[30] == 1'b0, "R5 fields kept",
              r[25:16], {regList[ri], 5'(p)});
        check(cy < 300, "R12 latency", cy, 300);
      end
    end
    check(taViol == 0, "R9 turnaround released", taViol, 0);

    // R7 / R4 writes
    foreach (wPhy[a]) foreach (wReg[b]) foreach (wDat[c]) begin
      userOp(1'b1, wPhy[a], wReg[b], wDat[c], r, cy);
      check(r[29] == 1'b1, "R7 write ack", r[29], 1);
      check({lastWrPhy, lastWrReg, lastWrData} == {wPhy[a], wReg[b], wDat[c]},
            "R4 write frame", {lastWrPhy, lastWrReg, lastWrData}, {wPhy[a], wReg[b], wDat[c]});
    end
    check(taBad == 0, "R4 write turnaround", taBad, 0);

    // R8 second command while GO set is ignored
    rc = wrCount;
    regWrite(2'd2, {1'b1, 1'b1, 1'b0, 3'b000, 5'd9, 5'd4, 16'h1234});
    regWrite(2'd2, {1'b1, 1'b0, 1'b0, 3'b000, 5'd1, 5'd0, 16'h0000});
    waitGo(r, cy);
    check(r == {1'b0, 1'b1, 1'b1, 3'b000, 5'd9, 5'd4, 16'h1234}, "R8 user reg", r,
          {1'b0, 1'b1, 1'b1, 3'b000, 5'd9, 5'd4, 16'h1234});
    repeat (400) @(negedge clk);
    check(wrCount == rc + 1, "R8 one frame", wrCount, rc + 1);
    check({lastWrPhy, lastWrReg, lastWrData} == {5'd4, 5'd9, 16'h1234}, "R8 frame content",
          {lastWrPhy, lastWrReg, lastWrData}, {5'd4, 5'd9, 16'h1234});

    // R3 divider 3
    regWrite(2'd0, 32'h4000_0003);
    repeat (1200) @(negedge clk);
    check(period == 8, "R3 div3 period", period, 8);
    userOp(1'b0, 5'd5, 5'd12, 16'h0, r, cy);
    check(r[29] && r[15:0] == phyVal(5'd5, 5'd12), "R6 read at div3", r, phyVal(5'd5, 5'd12));

    // R10 a PHY disappears, another appears
    presentMask = 32'h8000_0801;
    repeat (20000) @(negedge clk);
    regRead(2'd1, r); check(r == presentMask, "R10 alive update", r, presentMask);

    // R2 disable stops frames after the current one
    regWrite(2'd0, 32'h0000_0003);
    cy = 0;
    do begin regRead(2'd0, r); cy++; end while (!r[31] && cy < 2000);
    check(r[31] == 1'b1, "R2 idle after disable", r[31], 1);
    rc = riseCount;
    repeat (300) @(negedge clk);
    check(riseCount == rc && !mdc && !mdioOe, "R2 quiet", riseCount, rc);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule